// File: doc/BRIEF.md
# Dual-Priority Output Queue with Critical Spillover

This block manages the frame queue of one output port in a switched network fabric. An instance sits in front of each port transmitter. Frame descriptors arrive with a class bit and a frame handle. The payload itself is stored elsewhere. Critical descriptors go into a dedicated critical FIFO. Non-critical descriptors go into a second store, called the shared store. The transmitter sees one descriptor at a time through a valid/ready handshake. Critical work is always offered ahead of non-critical work.

The shared store also protects critical traffic. Each shared-store entry carries a class tag. If the critical FIFO is full, or a fault input declares it unusable, an arriving critical descriptor is written into the shared store with its tag set. It therefore survives instead of being lost. Tagged entries are offered ahead of untagged ones.

While any tagged entry is waiting, later critical arrivals follow it into the shared store. This keeps critical frames in arrival order across both stores. A descriptor that cannot be stored anywhere is discarded, and one of two one-cycle drop pulses reports it. The fabric instantiates one copy per output port, so the port count of the switch is a parameter of the surrounding fabric and not of this block.

Top module: `prio_spill_queue`

## Requirements
- R1: While reset is asserted, and until the first arrival after reset, `out_valid`, `drop_nc` and `drop_crit` are 0.
- R2: A critical arrival (`in_crit`=1) is written to the critical FIFO when three conditions hold at the start of the cycle: `crit_fault` is 0, the FIFO is not full, and the shared store holds no tagged entry. A non-critical arrival (`in_crit`=0) is written to the shared store with its tag clear.
- R3: When no descriptor is being held, the offered descriptor follows a fixed order. The head of the critical FIFO comes first, if the FIFO is non-empty. Next comes the oldest tagged shared-store entry. Last comes the oldest shared-store entry. `out_crit`=1 marks a critical descriptor, whether it came from the FIFO or from a tagged shared-store entry.
- R4: Within each class, descriptors leave in arrival order.
- R5: A critical arrival that finds the critical FIFO full is written into the shared store with its tag set, provided the shared store is not full.
- R6: While `crit_fault` is 1, no entry is written into the critical FIFO. Every critical arrival goes to the shared store. Entries already in the FIFO are still delivered.
- R7: While the shared store holds a tagged entry, every critical arrival is routed to the shared store, even if the FIFO has room and no fault is flagged.
- R8: A non-critical arrival that finds the shared store full is discarded. `drop_nc` is 1 for exactly the following cycle.
- R9: A critical arrival that is routed to the shared store and finds it full is discarded. `drop_crit` is 1 for exactly the following cycle.
- R10: While `out_valid`=1 and `out_ready`=0, `out_handle` and `out_crit` stay unchanged in the next cycle. This holds even if a higher-priority arrival comes in meanwhile.
- R11: An arrival and a departure may happen in the same cycle. Fullness is judged on the occupancy at the start of that cycle. Every stored descriptor is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A descriptor is offered this cycle |
| in_crit | input | 1 | Class of the offered descriptor, 1 = critical |
| in_handle | input | HANDLE_W | Frame handle of the offered descriptor |
| crit_fault | input | 1 | Critical FIFO must not be written |
| out_valid | output | 1 | A descriptor is offered to the transmitter |
| out_ready | input | 1 | Transmitter takes the offered descriptor |
| out_handle | output | HANDLE_W | Handle of the offered descriptor |
| out_crit | output | 1 | Class of the offered descriptor, 1 = critical |
| drop_nc | output | 1 | One-cycle pulse, a non-critical arrival was discarded |
| drop_crit | output | 1 | One-cycle pulse, a critical arrival was discarded |

## Verification
The bench first fills the critical FIFO until it overflows. It then checks that the spilled entry leaves after the FIFO entries but before older non-critical frames. A design that drops instead of spilling would skip that handle. A design that ignores the tag would send the spilled frame after the non-critical ones.

The bench toggles the fault flag and lets the FIFO drain between spills. A design that writes the FIFO under fault, or that refills the FIFO while tagged entries wait, would reorder critical frames. The bench stalls the transmitter while critical arrivals come in, which catches a design whose offered descriptor jumps before it is taken. Long mixed sweeps with full stores and simultaneous enqueue and dequeue expose lost or duplicated handles and off-by-one drop decisions.

// File: rtl/spq_pkg.sv
package spq_pkg;
  typedef enum logic {
    SRC_CRIT = 1'b0,
    SRC_SHARED = 1'b1
  } spq_src_e;
endpackage

// File: rtl/spq_rst_sync.sv
module spq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/spq_fifo.sv
module spq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (push) wr_n = bump(wr_q);
    if (pop)  rd_n = bump(rd_q);
    cnt_n = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end

  assign head  = mem_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;

  // R11: never read an empty FIFO, never write a full one
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/spq_tag_store.sv
module spq_tag_store #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             push_tag,
  input  logic             pop,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] pop_idx,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  output logic             rd_tag,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] sel_idx,
  output logic             any_tag,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  data_q [DEPTH];
  logic [W-1:0]  data_n [DEPTH];
  logic [DEPTH-1:0] tag_q, tag_n;
  logic [CW-1:0] cnt_q, cnt_n, wr_pos;

  // entries are kept packed in arrival order, index 0 oldest
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      data_n[i] = data_q[i];
      tag_n[i]  = tag_q[i];
    end
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IW'(i) >= pop_idx) begin
          data_n[i] = data_q[i+1];
          tag_n[i]  = tag_q[i+1];
        end
      end
      tag_n[DEPTH-1] = 1'b0;
    end
    wr_pos = cnt_q - CW'(pop);
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == wr_pos) begin
          data_n[i] = push_data;
          tag_n[i]  = push_tag;
        end
      end
    end
    cnt_n = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tag_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      tag_q <= tag_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push || pop) begin
      for (int i = 0; i < DEPTH; i++) data_q[i] <= data_n[i];
    end
  end

  // oldest valid tagged entry, else the oldest entry
  always_comb begin
    sel_idx = '0;
    any_tag = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (tag_q[i] && (CW'(i) < cnt_q)) begin
        sel_idx = IW'(i);
        any_tag = 1'b1;
      end
    end
  end

  assign rd_data = data_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;

  // R11: a departure names a live entry; no write past capacity
  a_r11_pop_live: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (CW'(pop_idx) < cnt_q));
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r3_tag_first: assert property (@(posedge clk) disable iff (!rst_n)
    any_tag |-> tag_q[sel_idx]);
endmodule

// File: rtl/prio_spill_queue.sv
module prio_spill_queue #(
  parameter int HANDLE_W   = 8,
  parameter int CRIT_DEPTH = 4,
  parameter int NC_DEPTH   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_crit,
  input  logic [HANDLE_W-1:0] in_handle,
  input  logic                crit_fault,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [HANDLE_W-1:0] out_handle,
  output logic                out_crit,
  output logic                drop_nc,
  output logic                drop_crit
);
  import spq_pkg::*;

  localparam int NIW = (NC_DEPTH > 1) ? $clog2(NC_DEPTH) : 1;
  localparam int CCW = $clog2(CRIT_DEPTH+1);
  localparam int NCW = $clog2(NC_DEPTH+1);

  logic rst_n_s;

  logic                c_push, c_pop, c_empty, c_full;
  logic [HANDLE_W-1:0] c_head;
  logic [CCW-1:0]      c_count;

  logic                n_push, n_pop, n_empty, n_full, n_any_tag, n_rd_tag;
  logic [HANDLE_W-1:0] n_rd_data;
  logic [NIW-1:0]      n_sel, n_idx;
  logic [NCW-1:0]      n_count;

  logic       crit_path_ok, to_shared, accept;
  spq_src_e   src;
  logic       held_q, held_n;
  spq_src_e   held_src_q, held_src_n;
  logic [NIW-1:0] held_idx_q, held_idx_n;
  logic       drop_nc_q, drop_nc_n, drop_crit_q, drop_crit_n;

  spq_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  spq_fifo #(.W(HANDLE_W), .DEPTH(CRIT_DEPTH)) u_crit (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (c_push),
    .push_data(in_handle),
    .pop      (c_pop),
    .head     (c_head),
    .empty    (c_empty),
    .full     (c_full),
    .count    (c_count)
  );

  spq_tag_store #(.W(HANDLE_W), .DEPTH(NC_DEPTH)) u_shared (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (n_push),
    .push_data(in_handle),
    .push_tag (in_crit),
    .pop      (n_pop),
    .pop_idx  (n_idx),
    .rd_idx   (n_idx),
    .rd_data  (n_rd_data),
    .rd_tag   (n_rd_tag),
    .sel_idx  (n_sel),
    .any_tag  (n_any_tag),
    .empty    (n_empty),
    .full     (n_full),
    .count    (n_count)
  );

  // admission: class selection, spillover and drop decisions
  always_comb begin
    crit_path_ok = !crit_fault && !c_full && !n_any_tag;
    c_push       = in_valid && in_crit && crit_path_ok;
    to_shared    = in_valid && (!in_crit || !crit_path_ok);
    n_push       = to_shared && !n_full;
    drop_nc_n    = in_valid && !in_crit && n_full;
    drop_crit_n  = in_valid && in_crit && !crit_path_ok && n_full;
  end

  // dequeue arbitration with a lock while the transmitter stalls
  always_comb begin
    if (held_q) begin
      src   = held_src_q;
      n_idx = held_idx_q;
    end else begin
      src   = c_empty ? SRC_SHARED : SRC_CRIT;
      n_idx = n_sel;
    end
    out_valid  = !c_empty || !n_empty;
    out_handle = (src == SRC_CRIT) ? c_head : n_rd_data;
    out_crit   = (src == SRC_CRIT) ? 1'b1 : n_rd_tag;
    accept     = out_valid && out_ready;
    c_pop      = accept && (src == SRC_CRIT);
    n_pop      = accept && (src == SRC_SHARED);
    held_n     = out_valid && !out_ready;
    held_src_n = src;
    held_idx_n = n_idx;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      held_q      <= 1'b0;
      held_src_q  <= SRC_CRIT;
      held_idx_q  <= '0;
      drop_nc_q   <= 1'b0;
      drop_crit_q <= 1'b0;
    end else begin
      held_q      <= held_n;
      held_src_q  <= held_src_n;
      held_idx_q  <= held_idx_n;
      drop_nc_q   <= drop_nc_n;
      drop_crit_q <= drop_crit_n;
    end
  end

  assign drop_nc   = drop_nc_q;
  assign drop_crit = drop_crit_q;

  // R10: offered descriptor frozen while stalled
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_handle) && $stable(out_crit)));
  // R3: with no lock, a non-empty critical FIFO wins
  a_r3_crit_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!held_q && !c_empty) |-> (out_valid && out_crit));
  // R6: no growth of the critical FIFO under fault
  a_r6_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    crit_fault |=> (c_count <= $past(c_count)));
  // R5: a spill into a non-full shared store with no departure grows it
  a_r5_spill_grows: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && in_crit && c_full && !n_full && !n_pop) |=> (n_count > $past(n_count)));
  // R8 / R9: drop pulses only follow a matching arrival
  a_r8_drop_cause: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(drop_nc) |-> $past(in_valid && !in_crit));
  a_r9_drop_cause: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(drop_crit) |-> $past(in_valid && in_crit));
endmodule

// File: tb/prio_spill_queue_tb.sv
`timescale 1ns/1ps
module prio_spill_queue_tb_top;
  localparam int HW = 8;
  localparam int CD = 2;
  localparam int ND = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, in_valid, in_crit, crit_fault, out_ready;
  logic [HW-1:0] in_handle;
  logic          out_valid, out_crit, drop_nc, drop_crit;
  logic [HW-1:0] out_handle;

  prio_spill_queue #(.HANDLE_W(HW), .CRIT_DEPTH(CD), .NC_DEPTH(ND)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_crit(in_crit),
    .in_handle(in_handle), .crit_fault(crit_fault), .out_valid(out_valid),
    .out_ready(out_ready), .out_handle(out_handle), .out_crit(out_crit),
    .drop_nc(drop_nc), .drop_crit(drop_crit)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string ph = "R1";

  logic [HW-1:0] cq [$];
  logic [HW-1:0] nq_h [$];
  bit            nq_t [$];
  bit            m_held = 0, m_src_nc = 0, m_dn = 0, m_dc = 0;
  int            m_idx = 0;
  logic [HW-1:0] last_h = '0;
  logic [HW-1:0] hnext = 8'h01;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(string req, int got, int expv, string what);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", req, what, got, expv);
    end
  endtask

  task automatic step(bit v, bit c, bit fault, bit rdy);
    bit ev, src_nc, anytag, ok, nfull, acc, ec;
    int idx;
    logic [HW-1:0] eh;
    @(negedge clk);
    in_valid = v; in_crit = c; in_handle = hnext;
    crit_fault = fault; out_ready = rdy;
    ev = (cq.size() > 0) || (nq_h.size() > 0);
    anytag = 0; idx = 0;
    for (int i = nq_t.size() - 1; i >= 0; i--) if (nq_t[i]) begin idx = i; anytag = 1; end
    if (m_held) begin
      src_nc = m_src_nc; idx = m_idx;
    end else begin
      src_nc = (cq.size() == 0);
    end
    eh = '0; ec = 0;
    if (ev) begin
      if (!src_nc) begin eh = cq[0]; ec = 1; end
      else begin eh = nq_h[idx]; ec = nq_t[idx]; end
    end
    chk(ph, int'(out_valid), int'(ev), "valid");
    if (ev) begin
      chk(ph, int'(out_handle), int'(eh), "handle");
      chk(ph, int'(out_crit), int'(ec), "class");
    end
    if (m_held) chk("R10", int'(out_handle), int'(last_h), "held handle");
    chk("R8", int'(drop_nc), int'(m_dn), "nc drop");
    chk("R9", int'(drop_crit), int'(m_dc), "crit drop");
    acc   = ev && rdy;
    ok    = !fault && (cq.size() < CD) && !anytag;
    nfull = (nq_h.size() >= ND);
    m_dn  = v && !c && nfull;
    m_dc  = v && c && !ok && nfull;
    if (acc) begin
      if (!src_nc) void'(cq.pop_front());
      else begin nq_h.delete(idx); nq_t.delete(idx); end
    end
    if (v && c && ok) cq.push_back(hnext);
    else if (v && !nfull) begin nq_h.push_back(hnext); nq_t.push_back(c); end
    m_held = ev && !rdy; m_src_nc = src_nc; m_idx = idx; last_h = eh;
    hnext = hnext + 8'h01;
  endtask

  task automatic drain(bit fault);
    for (int k = 0; k < 20; k++) step(0, 0, fault, 1);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_crit = 0; in_handle = '0;
    crit_fault = 0; out_ready = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1", int'(out_valid), 0, "valid in reset");
      chk("R1", int'(drop_nc | drop_crit), 0, "drops in reset");
    end
    @(negedge clk); rst_n = 1;
    ph = "R1"; for (int k = 0; k < 4; k++) step(0, 0, 0, 0);

    // R2 / R3: non-critical first, then a critical overtakes the rest
    ph = "R2";
    step(0, 0, 0, 0);
    step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 1, 0, 0);
    ph = "R3"; step(0, 0, 0, 1); drain(0);

    // R5 / R9 / R8: overflow of the FIFO, then of the shared store
    ph = "R5";
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    ph = "R9"; step(1, 1, 0, 0);
    ph = "R8"; step(1, 0, 0, 0); step(0, 0, 0, 0);
    ph = "R5"; drain(0);

    // R7: FIFO frees a slot while a spilled entry still waits
    ph = "R7";
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
    step(1, 1, 0, 1); step(1, 1, 0, 1); step(1, 0, 0, 0); step(1, 1, 0, 1);
    drain(0);

    // R6: fault diverts every critical arrival, FIFO still drains
    ph = "R6";
    step(1, 1, 0, 0); step(1, 1, 1, 0); step(1, 0, 1, 0); step(1, 1, 1, 0);
    step(1, 1, 1, 0); step(1, 1, 1, 1); step(0, 0, 1, 1);
    drain(1); drain(0);

    // R10: stall on a non-critical entry while critical frames arrive
    ph = "R10";
    step(1, 0, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0); step(0, 0, 0, 0);
    drain(0);

    // R4: ordered sweep without fault
    ph = "R4";
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], 0, lfsr[2] & lfsr[5]);
    end
    drain(0);

    // R11: full mix with fault, stalls and simultaneous traffic
    ph = "R11";
    for (int k = 0; k < 6000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[7], lfsr[1] ^ lfsr[4], lfsr[8] & lfsr[11], lfsr[2] | lfsr[3]);
    end
    drain(0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule